// File: doc/BRIEF.md
# Keyed-Arm Watchdog Timer

This block is a watchdog timer for a 32 kHz timer domain, with a small word-addressed register bus. Software sets a reload value and an optional power-of-two prescaler. It arms or disarms the timer only by writing an ordered pair of key words to a key register. While the timer is armed, an up-counter advances on each prescaler output. When the counter rolls over past its all-ones value, the block raises a reset request for one cycle and reloads the counter. Software keeps the timer from expiring by writing a trigger register with a value that differs from the last one. The usual habit is to alternate a pattern with its complement.

The bus runs on the fast clock. The timer domain is represented by a one-cycle `tick_i` strobe, one per 32 kHz period. Writes to the control, reload, trigger and key registers are posted: the written value is held in a staging slot and takes effect on the next tick. Until then, a per-register pending flag can be read back. The revision and interface-configuration registers respond at once.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is disarmed, the reload and counter registers both hold 0xFFFB0000, control reads 0, no pending flag is set and `rst_req_o` is low.
- R2: A write to control (address 3), reload (address 5), trigger (address 6) or key (address 7) takes effect on the next `tick_i` cycle. Until then the status register (address 2) shows a flag for that register: bit 0 for control, bit 2 for reload, bit 3 for trigger and bit 4 for key. A second write before the tick replaces the staged value.
- R3: Applying 0xBBBB and then 0x4444 (low 16 bits) to the key register arms the timer. Applying 0xAAAA and then 0x5555 disarms it. Armed state changes only on tick cycles.
- R4: Any other applied key word returns the key sequencer to idle. 0xAAAA or 0xBBBB always starts a fresh sequence, even in the middle of another one.
- R5: While armed, the counter (address 4) adds one for every prescaler output. While disarmed it holds.
- R6: Control bit 5 enables the prescaler and control bits 4:2 hold the ratio exponent N. When enabled, the counter advances once every 2^N ticks. When disabled, it advances on every tick.
- R7: An applied trigger value that differs from the last applied trigger value (which is 0 after reset) loads the counter from the reload register, and this takes precedence over counting. An equal value has no effect.
- R8: When an armed counter at 0xFFFFFFFF advances, it loads the reload value and `rst_req_o` goes high for exactly one clock cycle.
- R9: Address 0 returns the revision code (0x31 by default) in bits 7:0. Address 1 bit 0 is a read/write interface-configuration bit that takes effect at once. Control and reload read back their applied values.
- R10: The counter changes only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe per timer-domain period |
| bus_addr_i | input | 3 | Word address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| rst_req_o | output | 1 | One-cycle reset request on counter rollover |

## Verification
The bench goes after several corner cases, each of which a broken design would get wrong in a visible way.

- **Posted writes:** it reads status and the old register value before the tick, and checks that a double write keeps only the second value. A design that applied writes at once, or kept the first staged value, would show the wrong reload.
- **Key sequencer:** it applies a foreign word between the two arming words, then starts a disarm word and lets an arm pair take over. A sequencer that did not clear on bad words, or did not restart on a first word, would leave the counter moving or frozen at the wrong time.
- **Trigger handling:** it repeats a trigger value and then changes it. A design that reloaded on every write, or counted in the same tick as a reload, would read back a different count.
- **Prescaler and rollover:** it checks the counter after a prescaler change, and runs the counter through its all-ones value. A wrong prescaler phase, a missed rollover reload, or a request pulse of the wrong length would each show as a different count or pulse total.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int PTV_W      = 3;
    localparam int PTV_LSB    = 2;
    localparam int PRE_EN_BIT = 5;
    localparam int CTRL_W     = PRE_EN_BIT + 1;
    localparam int DIV_W      = (1 << PTV_W) - 1;
    localparam int NSLOT      = 4;
    localparam int STAT_W     = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_REV    = 3'd0,
        A_SYSCFG = 3'd1,
        A_STAT   = 3'd2,
        A_CTRL   = 3'd3,
        A_COUNT  = 3'd4,
        A_LOAD   = 3'd5,
        A_TRIG   = 3'd6,
        A_KEY    = 3'd7
    } wdt_addr_e;

    typedef enum logic [1:0] {
        SL_CTRL = 2'd0,
        SL_LOAD = 2'd1,
        SL_TRIG = 2'd2,
        SL_KEY  = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_ARM1 = 2'd1,
        KS_DIS1 = 2'd2
    } key_st_e;

    typedef struct packed {
        logic             en;
        logic [PTV_W-1:0] ptv;
    } pre_cfg_t;

    localparam logic [KEY_W-1:0] KEY_ARM_FIRST  = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_ARM_SECOND = 16'h4444;
    localparam logic [KEY_W-1:0] KEY_DIS_FIRST  = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_DIS_SECOND = 16'h5555;

    function automatic logic [ADDR_W-1:0] slot_addr(int s);
        case (s)
            0:       return A_CTRL;
            1:       return A_LOAD;
            2:       return A_TRIG;
            default: return A_KEY;
        endcase
    endfunction

    function automatic int slot_stat_bit(int s);
        case (s)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] pre_mask(logic [PTV_W-1:0] ptv);
        return DIV_W'((32'd1 << ptv) - 32'd1);
    endfunction
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_i,
    output logic         pend_o,
    output logic         apply_o,
    output logic [W-1:0] data_o
);
    logic         pend_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (wr_i) begin
            data_q <= wdata_i;
            pend_q <= 1'b1;
        end else if (tick_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o  = pend_q;
    assign apply_o = tick_i && pend_q;
    assign data_o  = data_q;
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_i,
    input  logic [KEY_W-1:0] word_i,
    output logic             armed_o
);
    key_st_e st_q;
    logic    armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= KS_IDLE;
            armed_q <= 1'b0;
        end else if (apply_i) begin
            if (st_q == KS_ARM1 && word_i == KEY_ARM_SECOND) begin
                armed_q <= 1'b1;
                st_q    <= KS_IDLE;
            end else if (st_q == KS_DIS1 && word_i == KEY_DIS_SECOND) begin
                armed_q <= 1'b0;
                st_q    <= KS_IDLE;
            end else if (word_i == KEY_ARM_FIRST) begin
                st_q <= KS_ARM1;
            end else if (word_i == KEY_DIS_FIRST) begin
                st_q <= KS_DIS1;
            end else begin
                st_q <= KS_IDLE;
            end
        end
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  logic     run_i,
    input  pre_cfg_t cfg_i,
    output logic     fire_o
);
    logic [DIV_W-1:0] div_q;

    assign fire_o = run_i && tick_i && (!cfg_i.en || div_q == pre_mask(cfg_i.ptv));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            div_q <= '0;
        end else if (tick_i) begin
            div_q <= fire_o ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter logic [7:0]        REV_CODE = 8'h31,
    parameter logic [DATA_W-1:0] RST_LOAD = 32'hFFFB_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              rst_req_o
);
    logic [NSLOT-1:0]  pend;
    logic [NSLOT-1:0]  apply;
    logic [DATA_W-1:0] stage [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        wdt_post_slot #(.W(DATA_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_i    (bus_we_i && bus_addr_i == slot_addr(s)),
            .wdata_i (bus_wdata_i),
            .tick_i  (tick_i),
            .pend_o  (pend[s]),
            .apply_o (apply[s]),
            .data_o  (stage[s])
        );
    end

    logic armed;
    wdt_key_seq u_key (
        .clk     (clk),
        .rst     (rst),
        .apply_i (apply[SL_KEY]),
        .word_i  (stage[SL_KEY][KEY_W-1:0]),
        .armed_o (armed)
    );

    logic [CTRL_W-1:0] ctrl_q;
    pre_cfg_t          pre_cfg;
    logic              pre_fire;
    assign pre_cfg.en  = ctrl_q[PRE_EN_BIT];
    assign pre_cfg.ptv = ctrl_q[PTV_LSB +: PTV_W];

    wdt_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .run_i  (armed),
        .cfg_i  (pre_cfg),
        .fire_o (pre_fire)
    );

    logic [DATA_W-1:0] load_q, last_trig_q, cnt_q, load_eff;
    logic              sys_q, req_q, trig_hit;

    assign load_eff = apply[SL_LOAD] ? stage[SL_LOAD] : load_q;
    assign trig_hit = apply[SL_TRIG] && (stage[SL_TRIG] != last_trig_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            load_q      <= RST_LOAD;
            last_trig_q <= '0;
            cnt_q       <= RST_LOAD;
            sys_q       <= 1'b0;
            req_q       <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (bus_we_i && bus_addr_i == A_SYSCFG) sys_q <= bus_wdata_i[0];
            if (apply[SL_CTRL]) ctrl_q      <= stage[SL_CTRL][CTRL_W-1:0];
            if (apply[SL_LOAD]) load_q      <= stage[SL_LOAD];
            if (apply[SL_TRIG]) last_trig_q <= stage[SL_TRIG];
            if (trig_hit) begin
                cnt_q <= load_eff;
            end else if (pre_fire) begin
                if (&cnt_q) begin
                    cnt_q <= load_eff;
                    req_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign rst_req_o = req_q;

    always_comb begin
        bus_rdata_o = '0;
        case (wdt_addr_e'(bus_addr_i))
            A_REV:    bus_rdata_o[7:0] = REV_CODE;
            A_SYSCFG: bus_rdata_o[0]   = sys_q;
            A_STAT: begin
                for (int s = 0; s < NSLOT; s++) bus_rdata_o[slot_stat_bit(s)] = pend[s];
            end
            A_CTRL:   bus_rdata_o = DATA_W'(ctrl_q);
            A_COUNT:  bus_rdata_o = cnt_q;
            A_LOAD:   bus_rdata_o = load_q;
            A_TRIG:   bus_rdata_o = last_trig_q;
            default:  bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import wdt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              rst_req_o,
    input logic [NSLOT-1:0]  pend,
    input logic [DATA_W-1:0] cnt_q,
    input logic              armed
);
    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> $past(tick_i));  // R8
    AST_CNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));  // R10
    AST_ARM_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(armed));  // R3
    AST_LOAD_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we_i && bus_addr_i == A_LOAD) |=> pend[SL_LOAD]);  // R2
    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !bus_we_i) |=> (pend == '0));  // R2
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .rst_req_o  (rst_req_o),
    .pend       (pend),
    .cnt_q      (cnt_q),
    .armed      (armed)
);

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        rst_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    int req_seen = 0;

    always #5 clk = ~clk;

    keyed_wdt dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .rst_req_o   (rst_req_o)
    );

    always @(negedge clk) if (rst_req_o) req_seen++;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  req;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 37;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD, 8'd9, 3'd0, 32'h0,        32'h31},        // R9 revision
        '{OP_RD, 8'd1, 3'd4, 32'h0,        32'hFFFB0000},  // R1 counter reset
        '{OP_WR, 8'd2, 3'd5, 32'h100,      32'h0},
        '{OP_RD, 8'd2, 3'd2, 32'h0,        32'h4},         // R2 load pending
        '{OP_RD, 8'd2, 3'd5, 32'h0,        32'hFFFB0000},  // R2 not yet applied
        '{OP_TK, 8'd2, 3'd0, 32'd1,        32'h0},
        '{OP_RD, 8'd2, 3'd2, 32'h0,        32'h0},         // R2 drained
        '{OP_RD, 8'd9, 3'd5, 32'h0,        32'h100},       // R9 load readback
        '{OP_WR, 8'd7, 3'd6, 32'h1234,     32'h0},
        '{OP_TK, 8'd7, 3'd0, 32'd1,        32'h0},
        '{OP_RD, 8'd7, 3'd4, 32'h0,        32'h100},       // R7 reload while disarmed
        '{OP_WR, 8'd3, 3'd7, 32'hBBBB,     32'h0},
        '{OP_TK, 8'd3, 3'd0, 32'd1,        32'h0},
        '{OP_WR, 8'd3, 3'd7, 32'h4444,     32'h0},
        '{OP_RD, 8'd2, 3'd2, 32'h0,        32'h10},        // R2 key pending
        '{OP_TK, 8'd3, 3'd0, 32'd1,        32'h0},
        '{OP_TK, 8'd5, 3'd0, 32'd3,        32'h0},
        '{OP_RD, 8'd5, 3'd4, 32'h0,        32'h103},       // R5 counts when armed (R3)
        '{OP_WR, 8'd7, 3'd6, 32'h1234,     32'h0},
        '{OP_TK, 8'd7, 3'd0, 32'd1,        32'h0},
        '{OP_RD, 8'd7, 3'd4, 32'h0,        32'h104},       // R7 same value ignored
        '{OP_WR, 8'd7, 3'd6, 32'hEDCB,     32'h0},
        '{OP_TK, 8'd7, 3'd0, 32'd1,        32'h0},
        '{OP_RD, 8'd7, 3'd4, 32'h0,        32'h100},       // R7 reload wins over count
        '{OP_WR, 8'd6, 3'd3, 32'h24,       32'h0},
        '{OP_TK, 8'd6, 3'd0, 32'd5,        32'h0},
        '{OP_RD, 8'd6, 3'd4, 32'h0,        32'h103},       // R6 divide by two
        '{OP_RD, 8'd9, 3'd3, 32'h0,        32'h24},        // R9 control readback
        '{OP_WR, 8'd3, 3'd7, 32'hAAAA,     32'h0},
        '{OP_TK, 8'd3, 3'd0, 32'd1,        32'h0},
        '{OP_WR, 8'd3, 3'd7, 32'h5555,     32'h0},
        '{OP_TK, 8'd3, 3'd0, 32'd4,        32'h0},
        '{OP_RD, 8'd3, 3'd4, 32'h0,        32'h104},       // R3 disarmed holds
        '{OP_WR, 8'd9, 3'd1, 32'h1,        32'h0},
        '{OP_RD, 8'd9, 3'd1, 32'h0,        32'h1},         // R9 sysconfig immediate
        '{OP_WR, 8'd2, 3'd5, 32'h200,      32'h0},
        '{OP_WR, 8'd2, 3'd5, 32'h300,      32'h0}
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic rd_chk(input int req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr_i = a;
        #1;
        check(req, bus_rdata_o, exp);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(1, 3'd2, 32'h0);
        rd_chk(1, 3'd3, 32'h0);
        rd_chk(1, 3'd5, 32'hFFFB0000);
        check(1, {31'b0, rst_req_o}, 32'h0);
        tk(2);
        rd_chk(1, 3'd4, 32'hFFFB0000);  // R1 disarmed after reset

        for (int v = 0; v < NVEC; v++) begin
            case (VECS[v].op)
                OP_WR: wr(VECS[v].addr, VECS[v].data);
                OP_TK: tk(int'(VECS[v].data));
                default: rd_chk(int'(VECS[v].req), VECS[v].addr, VECS[v].exp);
            endcase
        end

        // R2 second write before the tick replaces the staged value
        rd_chk(2, 3'd2, 32'h4);
        tk(1);
        rd_chk(2, 3'd5, 32'h300);

        // R4 foreign word aborts arming
        wr(3'd3, 32'h0); tk(1);
        wr(3'd7, 32'hBBBB); tk(1);
        wr(3'd7, 32'h1111); tk(1);
        wr(3'd7, 32'h4444); tk(1);
        tk(2);
        rd_chk(4, 3'd4, 32'h104);
        // R4 first word restarts a sequence in progress
        wr(3'd7, 32'hAAAA); tk(1);
        wr(3'd7, 32'hBBBB); tk(1);
        wr(3'd7, 32'h4444); tk(1);
        tk(2);
        rd_chk(4, 3'd4, 32'h106);

        // R8 rollover
        wr(3'd5, 32'hFFFFFFFE); tk(1);
        wr(3'd6, 32'h5555); tk(1);
        rd_chk(7, 3'd4, 32'hFFFFFFFE);
        tk(1);
        rd_chk(8, 3'd4, 32'hFFFFFFFF);
        check(8, 32'(req_seen), 32'd0);
        tk(1);
        repeat (2) @(negedge clk);
        check(8, 32'(req_seen), 32'd1);
        rd_chk(8, 3'd4, 32'hFFFFFFFE);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule